// File: doc/BRIEF.md
# I2C Bus Recovery Clock Pulser

This block frees an I2C bus that a slave holds stuck after a transfer was cut short, for example by a reset in the middle of a read. When a slave is mid-byte and driving SDA low, no master can issue START or STOP. Clocking SCL until the slave finishes its byte and lets go of SDA clears the fault. The block takes the SCL pin away from the normal controller and drives it low for one delay period. It then issues full clock pulses, one delay period high and one low, for as long as the synchronised SDA reads low and fewer than ten pulses have been sent. It then parks SCL high for one more period and hands the pins back.

A recovery request is acted on only when the bus is actually in trouble: the controller still reports the bus busy, or SDA is sampled low. Otherwise the request is dropped. While a recovery runs, further requests are ignored. Completion is reported with a one-cycle done pulse and a held status bit that says whether SDA was found released. Issuing a STOP afterwards is left to the normal controller. All pins here are plain control and status pins. No data stream crosses the block, so there is no valid/ready handshake.

Top module: `i2c_unstick_top`

## Requirements
- R1: After reset `pin_own_o` is 0, `done_o` is 0, `recovered_o` is 0, and the SCL output is at its released level (level 1 in push-pull, pull-down enable 0 in open-drain).
- R2: A `start_i` pulse seen while idle begins recovery only if `bus_busy_i` is 1 or the synchronised SDA is 0. With the bus not busy and SDA high, the request has no effect: `pin_own_o` stays 0 and no `done_o` follows.
- R3: `start_i` pulses that arrive while a recovery is running are ignored. The pulse count and the single completion of that run are unchanged.
- R4: A recovery first drives SCL low for exactly `PERIOD_TICKS` cycles, starting in the same cycle that `pin_own_o` rises.
- R5: Each clock pulse drives SCL high for exactly `PERIOD_TICKS` cycles and then low for exactly `PERIOD_TICKS` cycles. The decision to send another pulse is made at the end of each low phase, including the first hold-low phase.
- R6: SDA is sampled through a two-flop synchroniser. Pulsing stops at the first low-phase end that sees SDA high, so a slave that releases SDA on its n-th clock (n ≤ 10) gets exactly n pulses.
- R7: No more than `MAX_PULSES` (default 10) pulses are issued, even if SDA never rises.
- R8: After the pulse loop, SCL is driven high for exactly `PERIOD_TICKS` cycles while `pin_own_o` is still 1. Then `pin_own_o` falls.
- R9: `done_o` is 1 for exactly one cycle: the first cycle in which `pin_own_o` is back at 0 after a recovery.
- R10: `recovered_o` is updated when `done_o` is raised and holds until the next completion. It is 1 if SDA read high when the pulse loop ended, and 0 if the loop ended at the pulse limit with SDA still low.
- R11: With `SCL_OPEN_DRAIN` = 1, `scl_o` is a pull-down enable: 1 means pull SCL low, 0 means release. It is therefore the inverse of the push-pull level for the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Recovery request strobe |
| bus_busy_i | input | 1 | Busy indication from the normal controller |
| sda_i | input | 1 | Raw SDA pin sample |
| scl_o | output | 1 | SCL drive: level (push-pull) or pull-down enable (open-drain) |
| pin_own_o | output | 1 | 1 while the pins are taken from the normal controller |
| done_o | output | 1 | One-cycle completion pulse |
| recovered_o | output | 1 | Held status: 1 if SDA was found released |

## Verification
A bus model holds SDA low until it has seen a chosen number of SCL rising edges. Recovery is run with release after 0 (busy bus only), 1, 3, 10 and never. These cases separate the first check after the hold-low phase, an ordinary early exit, the exact boundary where the last allowed pulse still succeeds, and the pulse-limit failure. Every SCL phase length is measured against the period, so a timer off by one cycle shows up. An idle request with SDA high and a repeated request in the middle of a run check that the trigger qualification and the busy lockout drop those strobes. An open-drain instance fed the same stimulus is compared against the push-pull instance at every sample.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HOLD   = 3'd1,
    ST_PHIGH  = 3'd2,
    ST_PLOW   = 3'd3,
    ST_PARK   = 3'd4
  } unstick_state_e;
endpackage

// File: rtl/i2c_unstick_sync.sv
module i2c_unstick_sync #(
  parameter int STAGES    = 2,
  parameter bit RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_LEVEL;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= RST_LEVEL;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_unstick_timer.sv
module i2c_unstick_timer #(
  parameter int PERIOD_TICKS = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expire_o
);
  localparam int CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= RELOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RELOAD); // R5
  AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == RELOAD)); // R4
endmodule

// File: rtl/i2c_unstick_fsm.sv
module i2c_unstick_fsm
  import i2c_unstick_pkg::*;
#(
  parameter int MAX_PULSES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bus_busy_i,
  input  logic sda_s_i,
  input  logic expire_i,
  output logic load_o,
  output logic scl_level_o,
  output logic own_o,
  output logic done_o,
  output logic recovered_o
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PULSES);

  unstick_state_e st_q;
  logic [PW-1:0]  pulses_q;
  logic           ok_pend_q;
  logic           done_q;
  logic           rec_q;
  logic           trigger;
  logic           more;

  assign trigger = start_i && (bus_busy_i || !sda_s_i);
  assign more    = !sda_s_i && (pulses_q < PMAX);
  assign load_o  = (st_q == ST_IDLE) ? trigger : expire_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      pulses_q  <= '0;
      ok_pend_q <= 1'b0;
      done_q    <= 1'b0;
      rec_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (trigger) begin
          st_q     <= ST_HOLD;
          pulses_q <= '0;
        end
        ST_HOLD, ST_PLOW: if (expire_i) begin
          if (more) begin
            st_q     <= ST_PHIGH;
            pulses_q <= pulses_q + 1'b1;
          end else begin
            st_q      <= ST_PARK;
            ok_pend_q <= sda_s_i;
          end
        end
        ST_PHIGH: if (expire_i) st_q <= ST_PLOW;
        ST_PARK: if (expire_i) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
          rec_q  <= ok_pend_q;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign own_o       = (st_q != ST_IDLE);
  assign scl_level_o = (st_q == ST_IDLE) || (st_q == ST_PHIGH) || (st_q == ST_PARK);
  assign done_o      = done_q;
  assign recovered_o = rec_q;

  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q <= PMAX); // R7
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!own_o && $past(own_o))); // R9
  AST_RELEASE_FROM_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own_o) |-> ($past(st_q) == ST_PARK)); // R8
  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PARK && !ok_pend_q) |-> (pulses_q == PMAX)); // R10
  AST_SCL_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !own_o |-> scl_level_o); // R1
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (own_o && st_q != ST_PARK) |=> own_o); // R3
endmodule

// File: rtl/i2c_unstick_top.sv
module i2c_unstick_top #(
  parameter int PERIOD_TICKS   = 125000,
  parameter int MAX_PULSES     = 10,
  parameter int SYNC_STAGES    = 2,
  parameter bit SCL_OPEN_DRAIN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bus_busy_i,
  input  logic sda_i,
  output logic scl_o,
  output logic pin_own_o,
  output logic done_o,
  output logic recovered_o
);
  logic sda_s;
  logic load;
  logic expire;
  logic scl_level;

  i2c_unstick_sync #(.STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (sda_i),
    .q_o   (sda_s)
  );

  i2c_unstick_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .expire_o (expire)
  );

  i2c_unstick_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bus_busy_i  (bus_busy_i),
    .sda_s_i     (sda_s),
    .expire_i    (expire),
    .load_o      (load),
    .scl_level_o (scl_level),
    .own_o       (pin_own_o),
    .done_o      (done_o),
    .recovered_o (recovered_o)
  );

  generate
    if (SCL_OPEN_DRAIN) begin : g_od
      assign scl_o = !scl_level;
    end else begin : g_pp
      assign scl_o = scl_level;
    end
  endgenerate

  AST_SCL_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_own_o |-> (scl_o == !SCL_OPEN_DRAIN)); // R11
endmodule

// File: tb/test_i2c_unstick_top.sv
module test_i2c_unstick_top;
  localparam int T    = 6;
  localparam int MAXP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy = 1'b0;
  logic sda = 1'b1;
  logic scl_pp, own, done, rec;
  logic scl_od, own_od, done_od, rec_od;

  always #4 clk = ~clk;

  i2c_unstick_top #(.PERIOD_TICKS(T), .MAX_PULSES(MAXP)) i_i2c_unstick_top (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bus_busy_i(busy), .sda_i(sda),
    .scl_o(scl_pp), .pin_own_o(own), .done_o(done), .recovered_o(rec));

  i2c_unstick_top #(.PERIOD_TICKS(T), .MAX_PULSES(MAXP), .SCL_OPEN_DRAIN(1'b1)) i_i2c_unstick_top_od (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bus_busy_i(busy), .sda_i(sda),
    .scl_o(scl_od), .pin_own_o(own_od), .done_o(done_od), .recovered_o(rec_od));

  typedef struct { int rises; bit ok; } exp_t;
  exp_t sb_q[$];

  int checks = 0;
  int fails = 0;
  int need = 0;
  int rises = 0;
  int seg = 0;
  int done_cnt = 0;
  int od_bad = 0;
  bit own_seen = 0;
  logic prev_scl = 1'b1;
  logic prev_own = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus model: SDA held low until 'need' SCL rising edges seen
  always @(negedge clk) sda <= (rises >= need);

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_od !== ~scl_pp) od_bad++;
      if (own) begin
        own_seen <= 1;
        if (!prev_own) begin
          seg <= 1;
          chk(scl_pp == 1'b0, "R4 first phase low", scl_pp, 0);
        end else if (scl_pp == prev_scl) seg <= seg + 1;
        else begin
          chk(seg == T, "R5 phase length", seg, T);
          seg <= 1;
          if (scl_pp) rises <= rises + 1;
        end
        chk(!done, "R9 done while owning", done, 0);
      end
      if (prev_own && !own) begin
        chk(seg == T, "R8 park high length", seg, T);
        chk(done == 1'b1, "R9 done at release", done, 1);
      end
      if (done) begin
        done_cnt <= done_cnt + 1;
        if (sb_q.size() == 0) chk(0, "R2/R3 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(rises == e.rises, "R6/R7 SCL rises incl park", rises, e.rises);
          chk(rec == e.ok, "R10 status", rec, e.ok);
        end
      end
      prev_scl <= scl_pp;
      prev_own <= own;
    end
  end

  task automatic run(input int n, input bit b, input bit poke);
    exp_t e;
    int d0;
    @(negedge clk);
    need = n; rises = 0; busy = b;
    repeat (4) @(negedge clk);
    e.rises = ((n <= MAXP) ? n : MAXP) + 1;
    e.ok = (n <= MAXP);
    sb_q.push_back(e);
    d0 = done_cnt;
    start = 1; @(negedge clk); start = 0; busy = 0;
    if (poke) begin
      repeat (3*T) @(negedge clk);
      start = 1; busy = 1; @(negedge clk); start = 0; busy = 0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 + 1, "R3 single completion", done_cnt - d0, 1);
    need = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(own == 0, "R1 own reset", own, 0);
    chk(scl_pp == 1 && scl_od == 0, "R1 scl released", scl_pp, 1);
    chk(done == 0 && rec == 0, "R1 status reset", rec, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R2: idle bus, SDA high, request dropped
    own_seen = 0;
    start = 1; @(negedge clk); start = 0;
    repeat (5*T) @(negedge clk);
    chk(own_seen == 0, "R2 request ignored", own_seen, 0);
    run(0, 1'b1, 1'b0);   // R2 busy only, no pulses
    run(1, 1'b0, 1'b0);   // R6
    run(3, 1'b0, 1'b1);   // R3 poke mid-run, R6
    run(10, 1'b0, 1'b0);  // R6/R7 boundary success
    run(99, 1'b0, 1'b0);  // R7 limit failure, R10
    chk(rec == 0, "R10 status held", rec, 0);
    run(2, 1'b0, 1'b0);
    chk(rec == 1, "R10 status updated", rec, 1);
    chk(od_bad == 0, "R11 open-drain inverse", od_bad, 0);
    chk(sb_q.size() == 0, "R9 all completions seen", sb_q.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule